// File: doc/BRIEF.md
# Fractional Output Clock Divider

This block sits after a frequency synthesizer and produces a clock-enable pulse train from the fast input clock. The divide ratio is set in fifths. A 6-bit code selects a ratio of code/5 + 1, so the ratio runs from 1.0 up to 13.6 in steps of 0.2. A plain integer counter cannot reach most of these ratios. The block therefore uses a phase accumulator. Each enabled input cycle it adds 5. When the total reaches code + 5, it emits one output enable and subtracts code + 5 from the total. Over time the average output rate equals the input rate divided by the selected ratio, and the gap between pulses alternates between the two integers either side of the ratio.

A configuration write latches a new code as pending. While the divider runs, a pending code waits for the next output pulse and takes effect there, with the phase restarted at zero. A busy flag covers the whole wait. While the divider is disabled, a pending code takes effect on the next clock. A 32-bit status word reports three flags: busy at bit 31, stable at bit 29 and enabled at bit 28. Downstream logic decodes these bit positions, so they are fixed.

Top module: `frac_clk_div`

## Requirements
- R1: Once running, every window of code+5 consecutive enabled cycles holds exactly 5 output enables. The average rate is therefore the input rate divided by (code/5 + 1).
- R2: With code 0 applied and the enable held high, `div_en` is high on every cycle, starting with the first enabled edge.
- R3: After `en` rises from low, the first output enable is registered on the ceil((code+5)/5)-th enabled edge. While `en` is low, `div_en` is 0 and the phase is cleared.
- R4: A `cfg_wr` strobe latches `cfg_code` as pending. `status[31]` (busy) reads 1 from the edge after the strobe until the code is applied. Until then the old ratio keeps running.
- R5: When running, a pending code is applied on the edge that produces an output enable (the boundary). Busy clears on that edge. The next output enable follows ceil((new+5)/5) cycles later.
- R6: A strobe that falls on a boundary edge is not applied at that boundary. It is applied at the next boundary, and the most recently written code wins.
- R7: While `en` is low, a pending code is applied on the first edge without a strobe, so busy reads 1 for exactly one cycle.
- R8: `status[29]` (stable) becomes 1 on the first output enable after enabling or after a code change. It clears on a strobe or when `en` goes low, and it is never 1 while busy is 1.
- R9: `status[28]` (enabled) follows `en` delayed by one cycle. All status bits other than 31, 29 and 28 read 0.
- R10: After reset, `div_en` is 0, the status word is 0 and the applied code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run the divider |
| cfg_wr | input | 1 | Strobe: latch `cfg_code` as the pending code |
| cfg_code | input | 6 | Ratio code; the ratio is code/5 + 1 |
| div_en | output | 1 | Divided clock enable, one input cycle wide |
| status | output | 32 | Bit 31 busy, bit 29 stable, bit 28 enabled, others 0 |

## Verification
Two events can land on the same clock edge: a configuration write and an output boundary where a pending code would be applied. The bench runs the divider at ratio 2. It latches one code right after a pulse, then strobes a second code exactly on the edge that produces the next pulse. The check passes when that pulse still appears with busy held, the next pulse follows at the old spacing and clears busy, and the gap after it matches the second code rather than the first.

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
  parameter int CODE_W = 6,
  parameter int STEP   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cfg_wr,
  input  logic [CODE_W-1:0] cfg_code,
  output logic              div_en,
  output logic [31:0]       status
);
  localparam int ACC_W = $clog2((1 << CODE_W) + 2 * STEP);
  localparam logic [ACC_W-1:0] STEP_V = ACC_W'(STEP);

  logic [CODE_W-1:0] act_code, pend_code;
  logic              pend, stable, en_q;
  logic [ACC_W-1:0]  acc, sum, modulus;
  logic              fire, apply;

  assign modulus = ACC_W'(act_code) + STEP_V;
  assign sum     = acc + STEP_V;
  assign fire    = en && (sum >= modulus);
  assign apply   = pend && !cfg_wr && (fire || !en);

  assign status = {pend, 1'b0, stable, en_q, 28'd0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_code  <= '0;
      pend_code <= '0;
      pend      <= 1'b0;
      stable    <= 1'b0;
      en_q      <= 1'b0;
      acc       <= '0;
      div_en    <= 1'b0;
    end else begin
      en_q   <= en;
      div_en <= fire;
      if (cfg_wr) begin
        pend      <= 1'b1;
        pend_code <= cfg_code;
      end else if (apply) begin
        pend <= 1'b0;
      end
      if (apply) act_code <= pend_code;
      if (!en || apply)  acc <= '0;
      else if (fire)     acc <= sum - modulus;
      else               acc <= sum;
      if (!en || cfg_wr) stable <= 1'b0;
      else if (fire)     stable <= 1'b1;
    end
  end

  AST_ACC_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    acc < modulus); // R1
  AST_CODE0_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_code == '0 && !pend) |=> div_en); // R2
  AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    div_en |-> $past(en)); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && en && !fire) |=> pend); // R4
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(act_code)); // R5
  AST_COLLIDE_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && fire) |=> (pend && div_en)); // R6
  AST_IDLE_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && pend && !cfg_wr) |=> !pend); // R7
  AST_STABLE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stable |-> !pend); // R8
  AST_STABLE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    stable |-> en_q); // R8
  AST_ENABLED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    status[28] == $past(en)); // R9
endmodule

// File: tb/frac_clk_div_bench.sv
module frac_clk_div_bench;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, cfg_wr = 1'b0;
  logic [5:0] cfg_code = '0;
  logic div_en;
  logic [31:0] status;
  int total = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  frac_clk_div u_frac_clk_div (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_wr(cfg_wr),
    .cfg_code(cfg_code), .div_en(div_en), .status(status)
  );

  wire busy_f = status[31];
  wire stab_f = status[29];
  wire enab_f = status[28];

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin step(); n++; end while (!div_en && n < 500);
  endtask

  task automatic t_reset();
    step();
    check("R10", "div_en after reset", int'(div_en), 0);
    check("R10", "status after reset", int'(status), 0);
    rst_n = 1'b1;
    step();
    check("R10", "status after release", int'(status), 0);
  endtask

  task automatic t_ratio(input int code);
    int n, cnt, k, nmod;
    nmod = code + 5;
    k = (nmod + 4) / 5;
    en = 1'b0;
    step(); step();
    check("R3", "div_en while disabled", int'(div_en), 0);
    cfg_wr = 1'b1; cfg_code = 6'(code);
    step();
    cfg_wr = 1'b0;
    check("R7", "busy after idle write", int'(busy_f), 1);
    step();
    check("R7", "busy one cycle later", int'(busy_f), 0);
    en = 1'b1;
    wait_pulse(n);
    check("R3", $sformatf("first pulse edge code %0d", code), n, k);
    check("R8", "stable at first pulse", int'(stab_f), 1);
    check("R9", "enabled while running", int'(enab_f), 1);
    check("R9", "unused status bits", int'(status & 32'h4FFF_FFFF), 0);
    cnt = 0;
    for (int i = 0; i < 3 * nmod; i++) begin step(); cnt += int'(div_en); end
    check("R1", $sformatf("pulses in 3 windows code %0d", code), cnt, 15);
  endtask

  task automatic t_code0();
    int cnt = 0;
    t_ratio(0);
    for (int i = 0; i < 12; i++) begin step(); cnt += int'(div_en); end
    check("R2", "code 0 every cycle", cnt, 12);
  endtask

  task automatic t_change();
    int n;
    t_ratio(5);
    wait_pulse(n);
    cfg_wr = 1'b1; cfg_code = 6'd10;
    step();
    cfg_wr = 1'b0;
    check("R4", "busy after write", int'(busy_f), 1);
    check("R8", "stable cleared by write", int'(stab_f), 0);
    check("R4", "no pulse yet", int'(div_en), 0);
    step();
    check("R5", "boundary pulse", int'(div_en), 1);
    check("R5", "busy cleared at boundary", int'(busy_f), 0);
    wait_pulse(n);
    check("R5", "gap after change", n, 3);
  endtask

  task automatic t_collide();
    int n;
    t_ratio(5);
    wait_pulse(n);
    cfg_wr = 1'b1; cfg_code = 6'd20;
    step();
    check("R6", "busy after first write", int'(busy_f), 1);
    check("R6", "no pulse before collision", int'(div_en), 0);
    cfg_code = 6'd15;
    step();
    cfg_wr = 1'b0;
    check("R6", "collision pulse", int'(div_en), 1);
    check("R6", "busy held at collision", int'(busy_f), 1);
    step();
    check("R6", "old spacing gap", int'(div_en), 0);
    step();
    check("R6", "deferred boundary pulse", int'(div_en), 1);
    check("R6", "busy cleared at deferred boundary", int'(busy_f), 0);
    wait_pulse(n);
    check("R6", "latest code gap", n, 4);
  endtask

  task automatic t_disable();
    en = 1'b0;
    step();
    check("R3", "div_en after disable", int'(div_en), 0);
    check("R9", "status after disable", int'(status), 0);
    step();
    check("R8", "stable stays low", int'(stab_f), 0);
  endtask

  initial begin
    t_reset();
    t_code0();
    t_ratio(1);
    t_ratio(7);
    t_ratio(63);
    t_change();
    t_collide();
    t_disable();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule